// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects event triggers from a set of sources and decides which one the processor core should service next. Each rising edge on a source line is synchronized and stored as a pending flag. A pending source becomes eligible once its device-side arm input, its controller enable bit and the global enable are all true. The one non-maskable source is always eligible. Among the eligible sources, the controller picks a winner by group priority, then by sub-priority, then by source number. It raises a request with the winner's source number as the vector, but only when the winner's group outranks the priority that is currently running.

The core takes the request with an acknowledge pulse. This clears the winner's pending flag and pushes its level onto a stack of active levels. An end-of-interrupt pulse pops the stack and restores the level that was running before, which allows handlers to nest. Software uses a small write port to set or clear enable and pending bits one source at a time. It uses a second port to load each source's group and sub-priority. A read port returns either the enable bits or the pending bits. The pending bits show every source that has fired, so a handler that serves several sources can tell which of them raised the request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `trig_i[i]` passes through two synchronizing flops and sets pending bit i. The bit is readable, and can be presented, after the third rising clock edge that follows the change. A second edge on a source that is still pending merges into the existing pending state. A trigger held high produces only one event.
- R2: A maskable source is presented only when it is pending, its `arm_i` bit is 1, its enable bit is 1 and `glob_en_i` is 1. While any of these is missing, the pending bit is kept. The conditions may become true in any order, and the request appears once the last one holds.
- R3: Arbitration uses the group priority first, where a numerically lower value wins. The sub-priority breaks a tie in group, again with the lower value winning. Any tie that remains goes to the lower source number. Both fields are loaded through `prio_we_i` with `prio_idx_i`, `prio_grp_i` and `prio_sub_i`. After reset every group is the maximum value and every sub-priority is 0.
- R4: `irq_o` is asserted only when the winner's level is strictly below the running level. The sub-priority never causes preemption.
- R5: Source `NMI_SRC` (default 0) ignores arm, enable and global enable. It has level 0, which is above every group. It is presented whenever it is pending and the running level is not 0.
- R6: A write with `wr_en_i` uses `wr_op_i` to select the action: 0 sets enables, 1 clears enables, 2 sets pending bits, 3 clears pending bits. Only the bit positions where `wr_mask_i` is 1 change.
- R7: `rd_data_o` returns the enable bits when `rd_sel_i` is 0 and the pending bits when it is 1. Several pending bits may be set at once.
- R8: `ack_i` while `irq_o` is high clears the pending bit of `vec_o` and pushes the winner's level. On the next cycle `act_lvl_o` shows that level: 0 for the non-maskable source, group+1 for any other source. `ack_i` without `irq_o` has no effect.
- R9: `eoi_i` pops the active stack and `act_lvl_o` returns to the level that ran before. When the stack is empty, `act_lvl_o` is all ones (15 with the default parameters).
- R10: After reset, all pending and enable bits are 0, `irq_o` is 0 and `act_lvl_o` is the idle value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | N_SRC | Asynchronous event lines, rising-edge sensitive |
| arm_i | input | N_SRC | Device-side arm bit per source |
| glob_en_i | input | 1 | Global enable for maskable sources |
| wr_en_i | input | 1 | Write strobe for enable/pending register operations |
| wr_op_i | input | 2 | Selects the write action (see R6) |
| wr_mask_i | input | N_SRC | One bit per source to affect |
| prio_we_i | input | 1 | Write strobe for priority fields |
| prio_idx_i | input | $clog2(N_SRC) | Source whose priority is written |
| prio_grp_i | input | PRIO_W | Group priority value |
| prio_sub_i | input | SUB_W | Sub-priority value |
| rd_sel_i | input | 1 | Selects enables (0) or pending bits (1) |
| rd_data_o | output | N_SRC | Read data |
| irq_o | output | 1 | Request to the core |
| vec_o | output | $clog2(N_SRC) | Source number of the presented request |
| ack_i | input | 1 | Core takes the presented request |
| eoi_i | input | 1 | Core finished the running handler |
| act_lvl_o | output | PRIO_W+1 | Running level; all ones when idle |

## Verification
The bench looks for ties at each step of the arbitration order. A design that compared sub-priority before group, or that broke final ties toward the higher source number, would present the wrong vector. It then runs a nested sequence in which a pending request of equal group but better sub-priority must wait for end-of-interrupt; a design that let sub-priority preempt would raise the request too early. It raises triggers while a mask condition is false and lifts the conditions one at a time, so a design that dropped masked triggers would never raise the request. It also holds a trigger high across an acknowledge, so a level-sensitive or re-arming latch would show the source pending again.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        OP_SET_EN   = 2'd0,
        OP_CLR_EN   = 2'd1,
        OP_SET_PEND = 2'd2,
        OP_CLR_PEND = 2'd3
    } wr_op_e;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = a_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise_o  = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N_SRC   = 8,
    parameter int PRIO_W  = 3,
    parameter int SUB_W   = 2,
    parameter int NMI_SRC = 0
) (
    input  logic [N_SRC-1:0]              elig_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  grp_i,
    input  logic [N_SRC-1:0][SUB_W-1:0]   sub_i,
    output logic                          valid_o,
    output logic [$clog2(N_SRC)-1:0]      idx_o,
    output logic [PRIO_W:0]               lvl_o
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int LVL_W = PRIO_W + 1;

    logic [LVL_W-1:0] cur_lvl;
    logic [SUB_W-1:0] cur_sub, best_sub;

    always_comb begin
        valid_o  = 1'b0;
        idx_o    = '0;
        lvl_o    = '1;
        best_sub = '1;
        cur_lvl  = '0;
        cur_sub  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (i == NMI_SRC) begin
                cur_lvl = '0;
                cur_sub = '0;
            end else begin
                cur_lvl = LVL_W'(grp_i[i]) + LVL_W'(1);
                cur_sub = sub_i[i];
            end
            if (elig_i[i] && (!valid_o || cur_lvl < lvl_o ||
                              (cur_lvl == lvl_o && cur_sub < best_sub))) begin
                valid_o  = 1'b1;
                idx_o    = IDX_W'(i);
                lvl_o    = cur_lvl;
                best_sub = cur_sub;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_SRC   = 8,
    parameter int PRIO_W  = 3,
    parameter int SUB_W   = 2,
    parameter int NMI_SRC = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            trig_i,
    input  logic [N_SRC-1:0]            arm_i,
    input  logic                        glob_en_i,
    input  logic                        wr_en_i,
    input  logic [1:0]                  wr_op_i,
    input  logic [N_SRC-1:0]            wr_mask_i,
    input  logic                        prio_we_i,
    input  logic [$clog2(N_SRC)-1:0]    prio_idx_i,
    input  logic [PRIO_W-1:0]           prio_grp_i,
    input  logic [SUB_W-1:0]            prio_sub_i,
    input  logic                        rd_sel_i,
    output logic [N_SRC-1:0]            rd_data_o,
    output logic                        irq_o,
    output logic [$clog2(N_SRC)-1:0]    vec_o,
    input  logic                        ack_i,
    input  logic                        eoi_i,
    output logic [PRIO_W:0]             act_lvl_o
);
    import irq_pkg::*;

    localparam int IDX_W = $clog2(N_SRC);
    localparam int LVL_W = PRIO_W + 1;
    localparam int DEPTH = (1 << PRIO_W) + 1;
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;
    localparam logic [N_SRC-1:0] NMI_MASK = N_SRC'(1) << NMI_SRC;

    typedef struct packed {
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0][PRIO_W-1:0] grp;
        logic [N_SRC-1:0][SUB_W-1:0]  sub;
        logic [DEPTH-1:0][LVL_W-1:0]  stk;
        logic [PTR_W-1:0]             ptr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] elig;
    logic             best_valid;
    logic [IDX_W-1:0] best_idx;
    logic [LVL_W-1:0] best_lvl;
    logic [LVL_W-1:0] run_lvl;
    logic             take;
    logic [PTR_W-1:0] ptr_pop;
    logic [N_SRC-1:0] pend_vis;

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        irq_edge_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_i    (trig_i[g]),
            .rise_o (rise[g])
        );
    end

    assign elig = st_q.pend & ((st_q.en & arm_i & {N_SRC{glob_en_i}}) | NMI_MASK);

    irq_arbiter #(
        .N_SRC   (N_SRC),
        .PRIO_W  (PRIO_W),
        .SUB_W   (SUB_W),
        .NMI_SRC (NMI_SRC)
    ) u_arb (
        .elig_i  (elig),
        .grp_i   (st_q.grp),
        .sub_i   (st_q.sub),
        .valid_o (best_valid),
        .idx_o   (best_idx),
        .lvl_o   (best_lvl)
    );

    always_comb begin
        run_lvl = IDLE_LVL;
        for (int d = 0; d < DEPTH; d++) begin
            if (int'(st_q.ptr) == d + 1) run_lvl = st_q.stk[d];
        end
        irq_o     = best_valid && (best_lvl < run_lvl);
        vec_o     = best_idx;
        act_lvl_o = run_lvl;
        rd_data_o = rd_sel_i ? st_q.pend : st_q.en;
        pend_vis  = st_q.pend;
        take      = ack_i && irq_o;

        st_d = st_q;

        // acknowledge clears first so a fresh edge in the same cycle survives
        if (take) st_d.pend[best_idx] = 1'b0;
        st_d.pend = st_d.pend | rise;

        if (wr_en_i) begin
            case (wr_op_e'(wr_op_i))
                OP_SET_EN:   st_d.en   = st_d.en | wr_mask_i;
                OP_CLR_EN:   st_d.en   = st_d.en & ~wr_mask_i;
                OP_SET_PEND: st_d.pend = st_d.pend | wr_mask_i;
                OP_CLR_PEND: st_d.pend = st_d.pend & ~wr_mask_i;
                default: ;
            endcase
        end

        if (prio_we_i && int'(prio_idx_i) < N_SRC) begin
            st_d.grp[prio_idx_i] = prio_grp_i;
            st_d.sub[prio_idx_i] = prio_sub_i;
        end

        ptr_pop = st_q.ptr;
        if (eoi_i && st_q.ptr != '0) ptr_pop = st_q.ptr - PTR_W'(1);
        st_d.ptr = ptr_pop;
        if (take) begin
            for (int d = 0; d < DEPTH; d++) begin
                if (int'(ptr_pop) == d) st_d.stk[d] = best_lvl;
            end
            st_d.ptr = ptr_pop + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.grp  <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_SRC   = 8,
    parameter int PRIO_W  = 3,
    parameter int NMI_SRC = 0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     glob_en_i,
    input logic                     irq_o,
    input logic [$clog2(N_SRC)-1:0] vec_o,
    input logic                     ack_i,
    input logic                     eoi_i,
    input logic [PRIO_W:0]          act_lvl_o,
    input logic [N_SRC-1:0]         pend_vis,
    input logic [PRIO_W:0]          best_lvl
);
    localparam logic [PRIO_W:0] IDLE_LVL = '1;

    assert_irq_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_vis[vec_o]);

    assert_glob_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && int'(vec_o) != NMI_SRC) |-> glob_en_i);

    assert_outranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (best_lvl < act_lvl_o));

    assert_nmi_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vis[NMI_SRC] && act_lvl_o != '0) |-> (irq_o && int'(vec_o) == NMI_SRC));

    assert_push_lvl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (act_lvl_o == $past(best_lvl)));

    assert_pop_lvl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && irq_o) && act_lvl_o != IDLE_LVL) |=> (act_lvl_o > $past(act_lvl_o)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_SRC   (N_SRC),
    .PRIO_W  (PRIO_W),
    .NMI_SRC (NMI_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en_i (glob_en_i),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .ack_i     (ack_i),
    .eoi_i     (eoi_i),
    .act_lvl_o (act_lvl_o),
    .pend_vis  (pend_vis),
    .best_lvl  (best_lvl)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trig = '0, arm = '0, wr_mask = '0;
    logic       glob = 1'b0, wr_en = 1'b0, prio_we = 1'b0, rd_sel = 1'b0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic [1:0] wr_op = '0;
    logic [2:0] prio_idx = '0, prio_grp = '0;
    logic [1:0] prio_sub = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [2:0] vec;
    logic [3:0] act;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N), .PRIO_W(3), .SUB_W(2), .NMI_SRC(0)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .arm_i(arm), .glob_en_i(glob),
        .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_mask_i(wr_mask),
        .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_grp_i(prio_grp),
        .prio_sub_i(prio_sub), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .irq_o(irq), .vec_o(vec), .ack_i(ack), .eoi_i(eoi), .act_lvl_o(act)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] arm;
        logic       glob;
        logic [7:0] trig;
        logic       exp_irq;
        logic [2:0] exp_vec;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [0:NV-1] = '{
        '{8'hFF, 8'hFF, 1'b1, 8'h02, 1'b1, 3'd1},   // R1 single source
        '{8'hFF, 8'hFF, 1'b1, 8'h06, 1'b1, 3'd2},   // R3 sub-priority tie-break
        '{8'hFF, 8'hFF, 1'b1, 8'h26, 1'b1, 3'd2},   // R3 group decides
        '{8'hFF, 8'hFF, 1'b1, 8'h58, 1'b1, 3'd4},   // R3 index tie-break
        '{8'h00, 8'h00, 1'b0, 8'h59, 1'b1, 3'd0},   // R5 NMI ignores masks
        '{8'h00, 8'hFF, 1'b1, 8'hFE, 1'b0, 3'd0},   // R2 enable missing
        '{8'hFF, 8'h00, 1'b1, 8'hFE, 1'b0, 3'd0},   // R2 arm missing
        '{8'hFF, 8'hFF, 1'b0, 8'hFE, 1'b0, 3'd0},   // R2 global missing
        '{8'hF7, 8'hFF, 1'b1, 8'h88, 1'b1, 3'd7},   // R2 disabled winner skipped
        '{8'hFF, 8'hDF, 1'b1, 8'h20, 1'b0, 3'd0},   // R2 disarmed
        '{8'hFF, 8'hFF, 1'b1, 8'hA0, 1'b1, 3'd5}    // R3 group 5 over 6
    };

    task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expv);
        n_chk++;
        if (actual !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expv);
        end
    endtask

    task automatic wr(input logic [1:0] op, input logic [7:0] m);
        @(negedge clk); wr_en = 1'b1; wr_op = op; wr_mask = m;
        @(negedge clk); wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic setprio(input int idx, input int g, input int s);
        @(negedge clk); prio_we = 1'b1; prio_idx = 3'(idx); prio_grp = 3'(g); prio_sub = 2'(s);
        @(negedge clk); prio_we = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); trig = trig | m;
        repeat (3) @(negedge clk);
        trig = trig & ~m;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        rd_sel = sel; #1; d = rd_data;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 irq", irq, 0);
        check("R10 act", act, 15);
        rd(1'b0, d); check("R10 enables", d, 0);
        rd(1'b1, d); check("R10 pending", d, 0);
        @(negedge clk); rst_n = 1'b1;

        setprio(1, 3, 1); setprio(2, 3, 0); setprio(3, 1, 3); setprio(4, 1, 2);
        setprio(5, 5, 0); setprio(6, 1, 2); setprio(7, 6, 0);

        for (int k = 0; k < NV; k++) begin
            wr(2'd3, 8'hFF);
            wr(2'd1, 8'hFF);
            wr(2'd0, TBL[k].en);
            arm = TBL[k].arm; glob = TBL[k].glob;
            pulse(TBL[k].trig);
            check($sformatf("R2/R3/R5 vector %0d irq", k), irq, TBL[k].exp_irq);
            if (TBL[k].exp_irq) check($sformatf("R3 vector %0d vec", k), vec, TBL[k].exp_vec);
        end

        // R7 status shows several sources
        wr(2'd3, 8'hFF); wr(2'd0, 8'hFF); arm = 8'hFF; glob = 1'b1;
        pulse(8'h06);
        rd(1'b1, d); check("R7 pending", d, 8'h06);
        rd(1'b0, d); check("R7 enables", d, 8'hFF);

        // R4/R8/R9 nesting
        wr(2'd3, 8'hFF);
        pulse(8'h02); do_ack();
        check("R8 act after ack", act, 4);
        rd(1'b1, d); check("R8 pending cleared", d, 0);
        pulse(8'h04);
        check("R4 sub-priority no preempt", irq, 0);
        do_eoi();
        check("R9 act idle", act, 15);
        check("R9 irq after eoi", irq, 1);
        check("R9 vec after eoi", vec, 2);
        do_ack();
        pulse(8'h20);
        check("R4 lower group waits", irq, 0);
        pulse(8'h08);
        check("R4 preempt irq", irq, 1);
        check("R4 preempt vec", vec, 3);
        do_ack();
        check("R8 nested act", act, 2);
        pulse(8'h01);
        check("R5 NMI preempts", vec, 0);
        check("R5 NMI irq", irq, 1);
        do_ack();
        check("R8 NMI level", act, 0);
        do_eoi(); check("R9 pop to 2", act, 2);
        do_eoi(); check("R9 pop to 4", act, 4);
        do_eoi(); check("R9 pop to idle", act, 15);
        check("R9 deferred vec", vec, 5);

        // R2 conditions in any order
        wr(2'd3, 8'hFF); wr(2'd1, 8'h08);
        pulse(8'h08);
        check("R2 masked no irq", irq, 0);
        rd(1'b1, d); check("R2 pending kept", d, 8'h08);
        glob = 1'b0; wr(2'd0, 8'h08);
        check("R2 global still off", irq, 0);
        @(negedge clk); glob = 1'b1; #1;
        check("R2 last condition irq", irq, 1);
        check("R2 last condition vec", vec, 3);

        // R1 merge and held level
        wr(2'd3, 8'hFF);
        pulse(8'h08); pulse(8'h08);
        do_ack();
        rd(1'b1, d); check("R1 merged pending", d, 0);
        do_eoi();
        @(negedge clk); trig[4] = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b1, d); check("R1 edge latency", d, 8'h10);
        do_ack();
        repeat (4) @(negedge clk);
        rd(1'b1, d); check("R1 held level once", d, 0);
        trig[4] = 1'b0;
        do_eoi();
        do_ack();
        check("R8 ack without irq ignored", act, 15);

        // R6 masked register writes
        wr(2'd2, 8'h40);
        rd(1'b1, d); check("R6 set pending", d, 8'h40);
        wr(2'd3, 8'h40);
        rd(1'b1, d); check("R6 clear pending", d, 0);
        wr(2'd1, 8'hFF); wr(2'd0, 8'h81);
        rd(1'b0, d); check("R6 set enable", d, 8'h81);
        wr(2'd1, 8'h01);
        rd(1'b0, d); check("R6 clear enable", d, 8'h80);

        // R10 reset mid-run
        wr(2'd2, 8'h81); do_ack();
        @(negedge clk); rst_n = 1'b0; #1;
        check("R10 irq after reset", irq, 0);
        check("R10 act after reset", act, 15);
        rd(1'b1, d); check("R10 pending after reset", d, 0);
        rd(1'b0, d); check("R10 enable after reset", d, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule